// File: doc/BRIEF.md
# Hot-Plug Event Latch and Interrupt Aggregator

This block collects hot-plug events for a group of expansion slots and turns them into one interrupt line and one system-error line. Each slot watches its raw status inputs: adapter presence, latch-switch (MRL) position, attention button, and two power-fault sources (isolated and connected). A qualifying edge on any of these sets a sticky event latch. Each latch has its own interrupt mask. The MRL-change latch and the connected-fault latch also have an error-line mask.

A controller word holds the global interrupt mask, the global error mask, the command-complete interrupt mask and the arbiter error mask. It also holds two sticky flags: command completion, raised by a pulse from the command engine, and arbiter error, raised by a pulse from the bus arbiter. A locator word gives, at a glance, which sources have an unmasked pending event.

Software reads and writes all of this through a simple word-addressed port. It clears latches by writing ones back into their positions. During servicing it sets the global interrupt mask to hold the line low.

Top module: `hp_event_agg`

## Requirements
- R1: An event latch sets on the clock after its raw input shows the qualifying edge. Presence (any change of the 2-bit field) goes to bit 16. A rising isolated fault goes to bit 17. A rising button goes to bit 18. A change of the MRL input goes to bit 19. A rising connected fault goes to bit 20. A falling fault or falling button sets nothing.
- R2: A latch stays set after its input returns. Writing 1 to its bit in the slot word clears it. Writing 0 leaves it unchanged.
- R3: The slot word reflects the raw status inputs as follows: bit 6 is power good (0 when either fault input is high), bit 7 is button, bit 8 is MRL open, bit 9 is 66 MHz capable, bits 11:10 are presence (11 means empty), and bits 14:12 are the PCI-X capability.
- R4: Slot word bits 28:24 are the interrupt masks for bits 20:16, in the same order. Bit 29 masks the error line for MRL change, and bit 30 masks it for connected fault. All of these are read/write, and all reset to 1. Bits 15, 23:21 and 31 read as 0.
- R5: The controller word (address 0) has bit 0 as the global interrupt mask, bit 1 as the global error mask, bit 2 as the command-complete interrupt mask and bit 3 as the arbiter error mask. All four are read/write and reset to 1. Bits 16 and 17 are write-one-to-clear flags. Bits 15:4 and 31:18 read as 0.
- R6: The locator word (address 1) has bit 0 set when the command flag is set and its mask is clear. Bit i+1 is set when slot i has a latched event whose interrupt mask is clear. All other bits are 0.
- R7: The interrupt output is high exactly when the global interrupt mask is clear and the locator is nonzero. It is low in the cycle after a write that sets the global interrupt mask.
- R8: The error output is high exactly when the global error mask is clear and an unmasked error source is latched. The sources are an MRL-change or connected-fault latch with its error mask clear, or the arbiter flag with the arbiter mask clear.
- R9: A one-cycle command-complete pulse sets controller bit 16 on the next clock.
- R10: A one-cycle arbiter error pulse sets controller bit 17 on the next clock.
- R11: When a latch or flag is set and written clear in the same cycle, it ends up set.
- R12: Slot i lives at address i+2. Writes to the locator or to unused addresses change nothing, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cmd_done | input | 1 | Command-complete pulse |
| arb_err | input | 1 | Arbiter error pulse |
| st_prsnt | input | 2*NUM_SLOTS | Presence field per slot |
| st_iso_flt | input | NUM_SLOTS | Isolated power fault per slot |
| st_con_flt | input | NUM_SLOTS | Connected power fault per slot |
| st_button | input | NUM_SLOTS | Attention button per slot |
| st_mrl_open | input | NUM_SLOTS | MRL open per slot |
| st_cap66 | input | NUM_SLOTS | 66 MHz capable per slot |
| st_pcix | input | 3*NUM_SLOTS | PCI-X capability per slot |
| hp_irq | output | 1 | Aggregated interrupt |
| hp_serr | output | 1 | Aggregated system error |

## Verification
The two functions that can collide are a software write-one-to-clear and a fresh hardware edge on the same latch. The bench provokes this by driving the presence change and the clearing write on the same falling edge, so that both act at the next rising edge. The same method is applied to the command flag, using a cmd_done pulse together with a bit-16 write. Each case is judged by reading the word back one cycle later and expecting the bit still set; a second write then clears it.

// File: rtl/hp_agg_pkg.sv
package hp_agg_pkg;
  localparam int EV_NUM    = 5;
  localparam int LAT_LSB   = 16;
  localparam int IMASK_LSB = 24;
  localparam int SMASK_LSB = 29;
  localparam int STAT_LSB  = 6;

  // raw inputs that can raise events
  typedef struct packed {
    logic [1:0] prsnt;
    logic       iso;
    logic       con;
    logic       btn;
    logic       mrl;
  } raw_ev_t;

  // status field image, bits 14:6 of the slot word
  typedef struct packed {
    logic [2:0] pcix;
    logic [1:0] prsnt;
    logic       cap66;
    logic       mrl_open;
    logic       button;
    logic       pwr_ok;
  } slot_stat_t;

  // event order: 0 presence, 1 iso fault, 2 button, 3 MRL, 4 con fault
  function automatic logic [EV_NUM-1:0] edge_events(raw_ev_t cur, raw_ev_t prv);
    logic [EV_NUM-1:0] ev;
    ev[0] = (cur.prsnt != prv.prsnt);
    ev[1] = cur.iso & ~prv.iso;
    ev[2] = cur.btn & ~prv.btn;
    ev[3] = cur.mrl ^ prv.mrl;
    ev[4] = cur.con & ~prv.con;
    return ev;
  endfunction

  function automatic logic [31:0] pack_slot(slot_stat_t st, logic [EV_NUM-1:0] lat,
                                            logic [EV_NUM-1:0] im, logic [1:0] sm);
    logic [31:0] w;
    w = '0;
    w[STAT_LSB +: 9]       = st;
    w[LAT_LSB +: EV_NUM]   = lat;
    w[IMASK_LSB +: EV_NUM] = im;
    w[SMASK_LSB +: 2]      = sm;
    return w;
  endfunction

  function automatic logic [31:0] pack_ctl(logic [3:0] masks, logic cmd_det, logic arb_det);
    logic [31:0] w;
    w = '0;
    w[3:0] = masks;
    w[16]  = cmd_det;
    w[17]  = arb_det;
    return w;
  endfunction
endpackage

// File: rtl/hp_slot_unit.sv
module hp_slot_unit
  import hp_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  prsnt,
  input  logic        iso_flt,
  input  logic        con_flt,
  input  logic        button,
  input  logic        mrl_open,
  input  logic        cap66,
  input  logic [2:0]  pcix,
  input  logic        wr_en,
  input  logic [6:0]  wr_mask,
  input  logic [4:0]  wr_clr,
  output logic [31:0] rd_word,
  output logic [4:0]  lat_q,
  output logic        int_pend,
  output logic        serr_pend
);
  raw_ev_t    raw_cur, raw_prv;
  slot_stat_t stat;
  logic [4:0] ev_set, ev_clr, lat_nxt, imask;
  logic [1:0] smask;

  assign raw_cur = '{prsnt: prsnt, iso: iso_flt, con: con_flt, btn: button, mrl: mrl_open};
  assign ev_set  = edge_events(raw_cur, raw_prv);
  assign ev_clr  = wr_en ? wr_clr : 5'b0;
  // a new edge outranks a clearing write in the same cycle
  assign lat_nxt = ev_set | (lat_q & ~ev_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_prv <= raw_cur;
      lat_q   <= '0;
      imask   <= '1;
      smask   <= '1;
    end else begin
      raw_prv <= raw_cur;
      lat_q   <= lat_nxt;
      if (wr_en) begin
        imask <= wr_mask[4:0];
        smask <= wr_mask[6:5];
      end
    end
  end

  assign stat = '{pcix: pcix, prsnt: prsnt, cap66: cap66, mrl_open: mrl_open,
                  button: button, pwr_ok: ~(iso_flt | con_flt)};
  assign rd_word   = pack_slot(stat, lat_q, imask, smask);
  assign int_pend  = |(lat_q & ~imask);
  assign serr_pend = (lat_q[3] & ~smask[0]) | (lat_q[4] & ~smask[1]);
endmodule

// File: rtl/hp_ctl_unit.sv
module hp_ctl_unit
  import hp_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_mask,
  input  logic [1:0]  wr_clr,
  input  logic        cmd_done,
  input  logic        arb_err,
  output logic [3:0]  masks,
  output logic        cmd_det,
  output logic        arb_det,
  output logic [31:0] rd_word
);
  logic [1:0] clr;

  assign clr = wr_en ? wr_clr : 2'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masks   <= '1;
      cmd_det <= 1'b0;
      arb_det <= 1'b0;
    end else begin
      if (wr_en) masks <= wr_mask;
      cmd_det <= cmd_done | (cmd_det & ~clr[0]);
      arb_det <= arb_err  | (arb_det & ~clr[1]);
    end
  end

  assign rd_word = pack_ctl(masks, cmd_det, arb_det);
endmodule

// File: rtl/hp_irq_merge.sv
module hp_irq_merge #(
  parameter int NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] slot_int,
  input  logic [NUM_SLOTS-1:0] slot_serr,
  input  logic [3:0]           masks,
  input  logic                 cmd_det,
  input  logic                 arb_det,
  output logic [31:0]          loc_word,
  output logic                 irq,
  output logic                 serr
);
  always_comb begin
    loc_word    = '0;
    loc_word[0] = cmd_det & ~masks[2];
    for (int i = 0; i < NUM_SLOTS; i++) loc_word[i+1] = slot_int[i];
  end

  assign irq  = ~masks[0] & (|loc_word);
  assign serr = ~masks[1] & ((|slot_serr) | (arb_det & ~masks[3]));
endmodule

// File: rtl/hp_event_agg.sv
// NUM_SLOTS must stay within 1..31 so the locator word can hold every slot.
module hp_event_agg #(
  parameter  int NUM_SLOTS = 4,
  localparam int ADDR_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_we,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   cmd_done,
  input  logic                   arb_err,
  input  logic [2*NUM_SLOTS-1:0] st_prsnt,
  input  logic [NUM_SLOTS-1:0]   st_iso_flt,
  input  logic [NUM_SLOTS-1:0]   st_con_flt,
  input  logic [NUM_SLOTS-1:0]   st_button,
  input  logic [NUM_SLOTS-1:0]   st_mrl_open,
  input  logic [NUM_SLOTS-1:0]   st_cap66,
  input  logic [3*NUM_SLOTS-1:0] st_pcix,
  output logic                   hp_irq,
  output logic                   hp_serr
);
  localparam int LAT_W = 5 * NUM_SLOTS;

  logic                   ctl_we;
  logic [NUM_SLOTS-1:0]   slot_we;
  logic [NUM_SLOTS-1:0]   slot_int, slot_serr;
  logic [31:0]            slot_word [NUM_SLOTS];
  logic [LAT_W-1:0]       lat_flat;
  logic [3:0]             ctl_mask;
  logic                   cmd_det, arb_det;
  logic [31:0]            ctl_word, loc_word;
  logic                   unused_wdata;

  assign unused_wdata = ^{reg_wdata[31], reg_wdata[23:21], reg_wdata[15:4]};
  assign ctl_we = reg_we && (reg_addr == ADDR_W'(0));

  hp_ctl_unit u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_we),
    .wr_mask(reg_wdata[3:0]), .wr_clr(reg_wdata[17:16]),
    .cmd_done(cmd_done), .arb_err(arb_err),
    .masks(ctl_mask), .cmd_det(cmd_det), .arb_det(arb_det), .rd_word(ctl_word)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_we[i] = reg_we && (reg_addr == ADDR_W'(i + 2));
    hp_slot_unit u_slot (
      .clk(clk), .rst_n(rst_n),
      .prsnt(st_prsnt[2*i +: 2]), .iso_flt(st_iso_flt[i]), .con_flt(st_con_flt[i]),
      .button(st_button[i]), .mrl_open(st_mrl_open[i]), .cap66(st_cap66[i]),
      .pcix(st_pcix[3*i +: 3]),
      .wr_en(slot_we[i]), .wr_mask(reg_wdata[30:24]), .wr_clr(reg_wdata[20:16]),
      .rd_word(slot_word[i]), .lat_q(lat_flat[5*i +: 5]),
      .int_pend(slot_int[i]), .serr_pend(slot_serr[i])
    );
  end

  hp_irq_merge #(.NUM_SLOTS(NUM_SLOTS)) u_merge (
    .slot_int(slot_int), .slot_serr(slot_serr), .masks(ctl_mask),
    .cmd_det(cmd_det), .arb_det(arb_det),
    .loc_word(loc_word), .irq(hp_irq), .serr(hp_serr)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(0))      reg_rdata = ctl_word;
    else if (reg_addr == ADDR_W'(1)) reg_rdata = loc_word;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (reg_addr == ADDR_W'(i + 2)) reg_rdata = slot_word[i];
  end
endmodule

// File: rtl/hp_event_agg_chk.sv
module hp_event_agg_chk #(
  parameter  int NUM_SLOTS = 4,
  localparam int ADDR_W    = $clog2(NUM_SLOTS + 2)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   reg_we,
  input logic [31:0]            reg_wdata,
  input logic [31:0]            reg_rdata,
  input logic [NUM_SLOTS-1:0]   st_button,
  input logic                   hp_irq,
  input logic                   hp_serr,
  input logic [3:0]             ctl_mask,
  input logic [31:0]            loc_word,
  input logic [5*NUM_SLOTS-1:0] lat_flat,
  input logic [NUM_SLOTS-1:0]   slot_we
);
  logic unused_chk;
  assign unused_chk = ^reg_wdata[31:1];

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mask[0] |-> !hp_irq);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(0) && reg_wdata[0]) |=> !hp_irq);
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_word == 32'h0) |-> !hp_irq);
  assert_serr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mask[1] |-> !hp_serr);
  assert_ctl_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> (reg_rdata[31:18] == 14'h0 && reg_rdata[15:4] == 12'h0));
  assert_slot_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(2) && int'(reg_addr) < NUM_SLOTS + 2)
      |-> ((reg_rdata & 32'h80E0_8000) == 32'h0));
  assert_loc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_word >> (NUM_SLOTS + 1)) == 32'h0);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    assert_button_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_button[i] && !$past(st_button[i])) |=> lat_flat[5*i + 2]);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[i] |=> ((lat_flat[5*i +: 5] & $past(lat_flat[5*i +: 5])) == $past(lat_flat[5*i +: 5])));
  end
endmodule

bind hp_event_agg hp_event_agg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/hp_event_agg_tb.sv
module hp_event_agg_tb;
  localparam int NS = 4;
  localparam int AW = $clog2(NS + 2);
  localparam logic [31:0] BASE = 32'h7F00_0C40;  // masks set, empty, power good

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cmd_done = 1'b0, arb_err = 1'b0;
  logic [2*NS-1:0] st_prsnt = '1;
  logic [NS-1:0] st_iso_flt = '0, st_con_flt = '0, st_button = '0, st_mrl_open = '0, st_cap66 = '0;
  logic [3*NS-1:0] st_pcix = '0;
  logic hp_irq, hp_serr;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hp_event_agg #(.NUM_SLOTS(NS)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_ev(input int s, input int e, input logic v);
    case (e)
      0: st_prsnt[2*s +: 2] = v ? 2'b10 : 2'b11;
      1: st_iso_flt[s]  = v;
      2: st_button[s]   = v;
      3: st_mrl_open[s] = v;
      default: st_con_flt[s] = v;
    endcase
  endtask

  task automatic pulse_ev(input int s, input int e);
    @(negedge clk); set_ev(s, e, 1'b1);
    @(negedge clk); set_ev(s, e, 1'b0);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(0, v); chk("R5 reset ctl", v, 32'h0000_000F);
    rd(1, v); chk("R6 reset loc", v, 32'h0);
    for (int s = 0; s < NS; s++) begin rd(s + 2, v); chk("R4 reset slot", v, BASE); end
    chk("R7 reset irq", 32'(hp_irq), 32'h0);
    chk("R8 reset serr", 32'(hp_serr), 32'h0);

    // status field mapping sweep
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
        st_prsnt[2*s +: 2] = 2'((p + s) % 4);
        st_cap66[s]    = 1'((p ^ s) & 1);
        st_pcix[3*s +: 3] = 3'((p + s) % 8);
        st_mrl_open[s] = 1'((p >> 1) & 1);
        st_button[s]   = 1'((p >> 2) & 1);
        st_iso_flt[s]  = (p == 5);
        st_con_flt[s]  = (p == 6);
      end
      #1;
      for (int s = 0; s < NS; s++) begin
        logic [31:0] e;
        e = (32'((p + s) % 8) << 12) | (32'((p + s) % 4) << 10) | (32'((p ^ s) & 1) << 9)
          | (32'((p >> 1) & 1) << 8) | (32'((p >> 2) & 1) << 7) | ((p == 5 || p == 6) ? 32'h0 : 32'h40);
        rd(s + 2, v); chk("R3 status map", v & 32'h7FC0, e);
      end
    end
    @(negedge clk);
    st_prsnt = '1; st_cap66 = '0; st_pcix = '0; st_mrl_open = '0; st_button = '0;
    st_iso_flt = '0; st_con_flt = '0;
    @(negedge clk);
    for (int s = 0; s < NS; s++) wr(s + 2, 32'h7F1F_0000);
    for (int s = 0; s < NS; s++) begin rd(s + 2, v); chk("R2 clear all", v, BASE); end

    // per-event latching, stickiness, write-0 and write-1 behaviour
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < 5; e++) begin
        pulse_ev(s, e);
        rd(s + 2, v); chk($sformatf("R1 latch s%0d e%0d", s, e), v, BASE | (32'h1 << (16 + e)));
        wr(s + 2, 32'h7F00_0000);
        rd(s + 2, v); chk("R2 write zero keeps", v, BASE | (32'h1 << (16 + e)));
        wr(s + 2, 32'h7F00_0000 | (32'h1 << (16 + e)));
        rd(s + 2, v); chk("R2 write one clears", v, BASE);
      end

    // falling edges set nothing
    @(negedge clk); st_button[1] = 1'b1; st_iso_flt[1] = 1'b1;
    @(negedge clk); wr(3, 32'h7F1F_0000);
    @(negedge clk); st_button[1] = 1'b0; st_iso_flt[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(3, v); chk("R1 falling ignored", v, BASE);

    // masks read/write, reserved zero
    wr(2, 32'h5500_0000);
    rd(2, v); chk("R4 mask write", v, 32'h5500_0C40);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R4 reserved zero", v, BASE);

    // locator and interrupt
    wr(0, 32'h0000_000E);
    wr(3, 32'h7F00_0000);
    pulse_ev(1, 2);
    rd(1, v); chk("R6 masked event", v, 32'h0);
    chk("R7 masked no irq", 32'(hp_irq), 32'h0);
    wr(4, 32'h7B00_0000);
    pulse_ev(2, 2);
    rd(1, v); chk("R6 locator slot2", v, 32'h8);
    chk("R7 irq high", 32'(hp_irq), 32'h1);
    wr(0, 32'h0000_000F);
    chk("R7 irq drops", 32'(hp_irq), 32'h0);
    wr(0, 32'h0000_000E);
    chk("R7 irq back", 32'(hp_irq), 32'h1);
    wr(4, 32'h7F04_0000); wr(3, 32'h7F1F_0000);
    rd(1, v); chk("R6 locator clear", v, 32'h0);
    chk("R7 irq clear", 32'(hp_irq), 32'h0);

    // error line
    wr(0, 32'h0000_000C);
    wr(3, 32'h5F00_0000);
    pulse_ev(1, 0);
    chk("R8 presence no serr", 32'(hp_serr), 32'h0);
    pulse_ev(1, 3);
    chk("R8 mrl serr", 32'(hp_serr), 32'h1);
    wr(0, 32'h0000_000E);
    chk("R8 global mask", 32'(hp_serr), 32'h0);
    wr(3, 32'h7F1F_0000);
    wr(0, 32'h0000_000C);
    wr(5, 32'h3F00_0000);
    pulse_ev(3, 4);
    chk("R8 con fault serr", 32'(hp_serr), 32'h1);
    wr(5, 32'h7F1F_0000);
    chk("R8 serr clear", 32'(hp_serr), 32'h0);

    // command completion flag
    wr(0, 32'h0000_000A);
    @(negedge clk); cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
    rd(0, v); chk("R9 cmd flag", v, 32'h0001_000A);
    rd(1, v); chk("R6 locator cmd", v, 32'h1);
    chk("R7 cmd irq", 32'(hp_irq), 32'h1);
    @(negedge clk); reg_addr = AW'(0); reg_wdata = 32'h0001_000A; reg_we = 1'b1; cmd_done = 1'b1;
    @(negedge clk); reg_we = 1'b0; cmd_done = 1'b0;
    rd(0, v); chk("R11 cmd set wins", v, 32'h0001_000A);
    wr(0, 32'h0001_000E);
    @(negedge clk); cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
    rd(1, v); chk("R6 cmd masked", v, 32'h0);
    wr(0, 32'h0001_000F);
    rd(0, v); chk("R9 cmd cleared", v, 32'h0000_000F);

    // arbiter flag
    wr(0, 32'h0000_0005);
    @(negedge clk); arb_err = 1'b1; @(negedge clk); arb_err = 1'b0;
    rd(0, v); chk("R10 arb flag", v, 32'h0002_0005);
    chk("R8 arb serr", 32'(hp_serr), 32'h1);
    wr(0, 32'h0002_000F);
    rd(0, v); chk("R10 arb cleared", v, 32'h0000_000F);
    chk("R8 arb serr off", 32'(hp_serr), 32'h0);

    // set and clear in the same cycle on a slot latch
    pulse_ev(0, 0);
    @(negedge clk);
    reg_addr = AW'(2); reg_wdata = 32'h7F01_0000; reg_we = 1'b1; st_prsnt[1:0] = 2'b10;
    @(negedge clk); reg_we = 1'b0;
    rd(2, v); chk("R11 slot set wins", v, 32'h7F01_0840);
    @(negedge clk); st_prsnt[1:0] = 2'b11;
    @(negedge clk);
    wr(2, 32'h7F01_0000);
    rd(2, v); chk("R11 then clears", v, BASE);

    // address map: ignored writes, unused reads
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'h0000_0000);
    wr(7, 32'h0000_0000);
    rd(0, v); chk("R12 ctl unchanged", v, 32'h0000_000F);
    rd(1, v); chk("R12 loc unchanged", v, 32'h0);
    rd(6, v); chk("R12 unused reads 0", v, 32'h0);
    for (int s = 0; s < NS; s++) begin rd(s + 2, v); chk("R12 slots unchanged", v, BASE); end
    summary();
  end
endmodule